// File: doc/BRIEF.md
# Coarse/Fine Delay Compensation Controller

This block closes the feedback loop around a jitter-sampling random bit source. The source sits behind a two-stage adjustable delay line. Each time the source finishes a bit, it presents the raw bit together with a one-cycle valid strobe. The controller keeps one compensation value. It moves the value one equal step up for a 1 and one equal step down for a 0, so over time the value follows the running sum of (2x-1). In steady state this pushes the source toward equal numbers of ones and zeros.

The compensation value is an unsigned offset-binary word of COARSE_W+FINE_W bits. Its low FINE_W bits drive the fine tap-select code and its high COARSE_W bits drive the coarse tap-select code. A full sweep of the fine code therefore spans exactly one coarse step, and a fine wrap carries into the coarse code or borrows from it. Only differential delay matters, so the codes start at mid-range after reset. The value stops at its two ends instead of wrapping, and a sticky flag records that an end was reached.

Top module: `dly_comp_ctrl`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets coarse_code to 2^(COARSE_W-1) and fine_code to 0, which is mid-range, and clears both saturation flags. A strobe present in the same cycle as the reset is ignored.
- R2: At a clock edge where bit_vld is 1, the compensation value {coarse_code, fine_code} rises by exactly 1 if bit_raw is 1 and falls by exactly 1 if bit_raw is 0. The new codes are visible right after that edge.
- R3: fine_code is the low FINE_W bits of the value and coarse_code is the high COARSE_W bits. Stepping up from fine_code = all ones makes fine_code 0 and adds 1 to coarse_code. Stepping down from fine_code = 0 makes fine_code all ones and subtracts 1 from coarse_code.
- R4: While bit_vld is 0, both codes hold their values whatever bit_raw does.
- R5: When the value is at its maximum (all ones), a further 1 leaves it at all ones instead of wrapping.
- R6: When the value is at its minimum (all zeros), a further 0 leaves it at zero instead of wrapping.
- R7: sat_hi goes to 1 in the same cycle that the value first becomes all ones, and sat_lo goes to 1 in the same cycle that it first becomes zero. Each flag is 0 before its limit is reached, and it then stays 1 until reset, even after the value moves away.
- R8: The up step and the down step are the same size, so any sequence with equally many ones and zeros that does not touch a limit returns the value to where it started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | One-cycle strobe: a new raw bit is present |
| bit_raw | input | 1 | Raw bit from the random source |
| coarse_code | output | COARSE_W | Coarse delay tap select (high part of the value) |
| fine_code | output | FINE_W | Fine delay tap select (low part of the value) |
| sat_lo | output | 1 | Sticky flag: the value has reached zero |
| sat_hi | output | 1 | Sticky flag: the value has reached all ones |

## Verification
The bench steps the value across the boundary between two coarse codes in both directions. A design that split the fields wrongly, or that forgot the carry or the borrow, would show a fine code that jumps while the coarse code stays put. It drives the value all the way to each end and then keeps pushing. A design that wrapped would jump to the opposite end, and one that set a flag a step early or one cycle late would be caught by the checks one step before the limit and exactly at it. It also toggles bit_raw with no strobe, sends a strobe in the same cycle as reset, and checks that the flags stay set after the value moves off a limit. These catch designs that update without a strobe, that let a strobe override reset, or whose flags are not sticky.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
   typedef enum logic {
      LIM_LO = 1'b0,
      LIM_HI = 1'b1
   } dcc_lim_e;

   localparam int DCC_NUM_LIMITS = 2;
   localparam int DCC_MAX_WIDTH  = 24;
endpackage

// File: rtl/dcc_accum.sv
module dcc_accum #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         bit_vld,
   input  logic         bit_raw,
   output logic [W-1:0] val_q,
   output logic [W-1:0] val_nxt
);
   localparam logic [W-1:0] CENTER = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] TOP    = '1;
   localparam logic [W-1:0] BOTTOM = '0;
   localparam logic [W-1:0] ONE    = W'(1);

   always_comb begin
      val_nxt = val_q;
      if (bit_vld) begin
         if (bit_raw) begin
            if (val_q != TOP) val_nxt = val_q + ONE;
         end else begin
            if (val_q != BOTTOM) val_nxt = val_q - ONE;
         end
      end
      if (rst) val_nxt = CENTER;
   end

   always_ff @(posedge clk) begin
      val_q <= val_nxt;
   end

   // R1: reset lands on centre
   assert_reset_center_R1: assert property (@(posedge clk)
      rst |=> (val_q == CENTER));

   // R2: one unit step up
   assert_step_up_R2: assert property (@(posedge clk) disable iff (rst)
      (bit_vld && bit_raw && val_q != TOP) |=> (val_q == $past(val_q) + ONE));

   // R2: one unit step down
   assert_step_down_R2: assert property (@(posedge clk) disable iff (rst)
      (bit_vld && !bit_raw && val_q != BOTTOM) |=> (val_q == $past(val_q) - ONE));

   // R4: hold without strobe
   assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
      !bit_vld |=> $stable(val_q));

   // R5: no wrap at the top
   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
      (bit_vld && bit_raw && val_q == TOP) |=> (val_q == TOP));

   // R6: no wrap at the bottom
   assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
      (bit_vld && !bit_raw && val_q == BOTTOM) |=> (val_q == BOTTOM));
endmodule

// File: rtl/dcc_satflag.sv
module dcc_satflag #(
   parameter int           W     = 8,
   parameter logic [W-1:0] LIMIT = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] val_nxt,
   output logic         flag
);
   always_ff @(posedge clk) begin
      if (rst) flag <= 1'b0;
      else     flag <= flag | (val_nxt == LIMIT);
   end

   // R7: flag is sticky until reset
   assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
      flag |=> flag);
endmodule

// File: rtl/dcc_split.sv
module dcc_split #(
   parameter int FINE_W   = 4,
   parameter int COARSE_W = 4,
   localparam int W       = FINE_W + COARSE_W
) (
   input  logic [W-1:0]        val,
   output logic [COARSE_W-1:0] coarse,
   output logic [FINE_W-1:0]   fine
);
   for (genvar b = 0; b < W; b++) begin : g_bit
      if (b < FINE_W) begin : g_fine
         assign fine[b] = val[b];
      end else begin : g_coarse
         assign coarse[b-FINE_W] = val[b];
      end
   end
endmodule

// File: rtl/dly_comp_ctrl.sv
module dly_comp_ctrl
   import dcc_pkg::*;
#(
   parameter int FINE_W          = 4,
   parameter int COARSE_W        = 4,
   parameter int HALF_FAST_STEPS = 5
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                bit_vld,
   input  logic                bit_raw,
   output logic [COARSE_W-1:0] coarse_code,
   output logic [FINE_W-1:0]   fine_code,
   output logic                sat_lo,
   output logic                sat_hi
);
   localparam int W = FINE_W + COARSE_W;
   localparam int COARSE_HALF_SPAN = 2 ** (COARSE_W - 1);

   initial begin
      assert (FINE_W >= 1) else $error("FINE_W must be at least 1");
      assert (COARSE_W >= 2) else $error("COARSE_W must be at least 2");
      assert (W <= DCC_MAX_WIDTH) else $error("value width too large");
      assert (COARSE_HALF_SPAN - 1 > HALF_FAST_STEPS)
         else $error("coarse range must exceed half a fast period either side");
   end

   logic [W-1:0]              val_q;
   logic [W-1:0]              val_nxt;
   logic [DCC_NUM_LIMITS-1:0] sat_vec;

   dcc_accum #(.W(W)) u_accum (
      .clk     (clk),
      .rst     (rst),
      .bit_vld (bit_vld),
      .bit_raw (bit_raw),
      .val_q   (val_q),
      .val_nxt (val_nxt)
   );

   for (genvar i = 0; i < DCC_NUM_LIMITS; i++) begin : g_lim
      localparam logic [W-1:0] LIM = (i == int'(LIM_HI)) ? '1 : '0;
      dcc_satflag #(.W(W), .LIMIT(LIM)) u_flag (
         .clk     (clk),
         .rst     (rst),
         .val_nxt (val_nxt),
         .flag    (sat_vec[i])
      );
   end

   dcc_split #(.FINE_W(FINE_W), .COARSE_W(COARSE_W)) u_split (
      .val    (val_q),
      .coarse (coarse_code),
      .fine   (fine_code)
   );

   assign sat_lo = sat_vec[int'(LIM_LO)];
   assign sat_hi = sat_vec[int'(LIM_HI)];

   // R7: flag high whenever its limit is held
   assert_hi_flag_R7: assert property (@(posedge clk) disable iff (rst)
      (val_q == '1) |-> sat_hi);
   assert_lo_flag_R7: assert property (@(posedge clk) disable iff (rst)
      (val_q == '0) |-> sat_lo);
   // R1: flags clear after reset
   assert_reset_flags_R1: assert property (@(posedge clk)
      rst |=> (!sat_hi && !sat_lo));
endmodule

// File: tb/sim_dly_comp_ctrl.sv
`timescale 1ns/1ps
module sim_dly_comp_ctrl;
   localparam int FW = 4;
   localparam int CW = 4;
   localparam int NV = 12;
   // each entry: {bit, expected {coarse,fine}} after that strobe, start 0x80
   localparam logic [8:0] VEC [NV] = '{
      {1'b1, 8'h81}, {1'b0, 8'h80}, {1'b0, 8'h7F}, {1'b0, 8'h7E},
      {1'b1, 8'h7F}, {1'b1, 8'h80}, {1'b1, 8'h81}, {1'b1, 8'h82},
      {1'b0, 8'h81}, {1'b0, 8'h80}, {1'b0, 8'h7F}, {1'b1, 8'h80}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic bit_vld = 1'b0;
   logic bit_raw = 1'b0;
   logic [CW-1:0] coarse_code;
   logic [FW-1:0] fine_code;
   logic sat_lo, sat_hi;
   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   dly_comp_ctrl #(.FINE_W(FW), .COARSE_W(CW)) u0 (
      .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_raw(bit_raw),
      .coarse_code(coarse_code), .fine_code(fine_code),
      .sat_lo(sat_lo), .sat_hi(sat_hi)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 200000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [8:0] code();
      return {1'b0, coarse_code, fine_code};
   endfunction

   task automatic step(input logic b);
      @(negedge clk);
      bit_vld = 1'b1;
      bit_raw = b;
      @(negedge clk);
      bit_vld = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      do_reset();
      chk("R1 reset codes", code(), 9'h080);
      chk("R1 reset flags", {7'd0, sat_hi, sat_lo}, 9'h000);

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][8]);
         chk("R2 R3 vector step", code(), {1'b0, VEC[i][7:0]});
      end

      // R4: toggling raw bit without strobe
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         bit_raw = ~bit_raw;
      end
      @(negedge clk);
      chk("R4 hold without strobe", code(), 9'h080);

      // R8: balanced pattern returns to start
      for (int i = 0; i < 10; i++) step(i[0]);
      chk("R8 balanced returns", code(), 9'h080);
      for (int i = 0; i < 3; i++) step(1'b1);
      for (int i = 0; i < 3; i++) step(1'b0);
      chk("R8 block balanced", code(), 9'h080);

      // R3: borrow then carry explicitly
      step(1'b0);
      chk("R3 borrow", code(), 9'h07F);
      step(1'b1);
      chk("R3 carry", code(), 9'h080);

      // R5/R7: climb to the top
      for (int i = 0; i < 126; i++) step(1'b1);
      chk("R7 hi flag before limit", {7'd0, sat_hi, sat_lo}, 9'h000);
      chk("R5 one below top", code(), 9'h0FE);
      step(1'b1);
      chk("R5 at top", code(), 9'h0FF);
      chk("R7 hi flag at limit", {7'd0, sat_hi, sat_lo}, 9'h002);
      step(1'b1);
      step(1'b1);
      chk("R5 no overflow", code(), 9'h0FF);
      step(1'b0);
      chk("R5 leave top", code(), 9'h0FE);
      chk("R7 hi flag sticky", {7'd0, sat_hi, sat_lo}, 9'h002);

      // R1: reset with strobe present
      @(negedge clk);
      rst = 1'b1; bit_vld = 1'b1; bit_raw = 1'b1;
      @(negedge clk);
      rst = 1'b0; bit_vld = 1'b0;
      chk("R1 reset beats strobe", code(), 9'h080);
      chk("R1 flags cleared", {7'd0, sat_hi, sat_lo}, 9'h000);

      // R6/R7: descend to the bottom
      for (int i = 0; i < 127; i++) step(1'b0);
      chk("R6 one above bottom", code(), 9'h001);
      chk("R7 lo flag before limit", {7'd0, sat_hi, sat_lo}, 9'h000);
      step(1'b0);
      chk("R6 at bottom", code(), 9'h000);
      chk("R7 lo flag at limit", {7'd0, sat_hi, sat_lo}, 9'h001);
      step(1'b0);
      chk("R6 no underflow", code(), 9'h000);
      step(1'b1);
      chk("R6 leave bottom", code(), 9'h001);
      chk("R7 lo flag sticky", {7'd0, sat_hi, sat_lo}, 9'h001);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule